// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master for Ethernet PHYs. A host programs it through four word-wide registers: a command word, a write-data word, a read-data word and a mode word. Each accepted command runs exactly one management frame on the two-wire bus, using either the older direct-register framing or the extended framing with device addressing. The block derives the management clock from the system clock, drives the data line or releases it for the turnaround and read data, and stores what it reads.

Software starts a frame by writing the command register. It then polls a busy flag until the frame ends. The write-data register holds the busy flag for write and address frames, and the read-data register holds it for read frames. After a read, a separate flag shows whether the PHY answered during the turnaround. A read that ends with this flag clear has failed.

One engine serves both framings. In extended mode the register field of the command names the target device, and an address frame sends the write-data word as the register address.

Top module: `mdio_master`

## Requirements
- R1: A host write to register 0 (command: opcode in bits 1:0, PHY address in bits 12:8, register/device field in bits 20:16) while no frame is busy starts one frame. For a read frame, bit 17 of register 2 (read data) is set from the next clock until the frame ends. For any other frame, bit 16 of register 1 (write data, value in bits 15:0) is set over the same span.
- R2: The management clock stays low while the block is idle. While a frame runs, each clock phase lasts N system clocks, where N is the divider field of register 3 (bits 7:0), and a value of 0 is taken as 1.
- R3: When the preamble bit (register 3 bit 8) is set, or when extended mode is on, a frame opens with 32 driven ones. Otherwise the frame opens directly with the start field.
- R4: With extended mode off (register 3 bit 9 = 0), a frame sends start 01, then the wire opcode (command opcode 0 gives 01 for write, 1 gives 10 for read), then the 5-bit PHY address and the 5-bit register address, all MSB first.
- R5: With extended mode on, a frame sends start 00, then the command opcode unchanged as the wire opcode (00 address, 01 write, 10 read with increment, 11 read), then the PHY address and the device number taken from the register field.
- R6: In a frame that is not a read, the master drives the turnaround as 1 then 0, followed by the 16 bits of the write-data register, MSB first.
- R7: In a read frame, the master releases the data line from the first turnaround bit to the end of the frame. It samples 16 data bits MSB first into register 2 bits 15:0. It sets register 2 bit 16 (valid) only if the second turnaround bit was sampled low. A new read clears valid.
- R8: The data line output and enable change only while the management clock is low. Input bits are sampled when the management clock rises.
- R9: While a frame is busy, host writes to any register have no effect: no second frame starts, and the command, write-data and mode registers keep their values.
- R10: After reset, all four registers read as zero, the management clock is low and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 2 | Host register select (0 cmd, 1 wdata, 2 rdata, 3 mode) |
| hostWrData | input | 32 | Host write value |
| hostRdData | output | 32 | Register selected by hostAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line input |

## Verification
A command written on one system clock edge sets its busy flag from the next edge, so the bench reads the flag one clock after the write. The first management clock rise comes N system clocks after the command is accepted. Each bit then takes 2N clocks. Busy clears, and the read data and valid flag update, on the falling edge that closes the last bit. For this reason the bench never checks results at a fixed cycle count. It records the driven value and enable just after every rising edge of the management clock, compares a frame only once the expected number of rises has arrived, and polls the busy flag before it reads any result. The PHY model changes its response only on falling edges, and the phase length is measured from the time between the first two rises.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int ADR_W      = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_WDAT = 2'd1;
  localparam logic [1:0] REG_RDAT = 2'd2;
  localparam logic [1:0] REG_MODE = 2'd3;

  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_REG_LSB  = 16;
  localparam int WDAT_PEND    = 16;
  localparam int RDAT_VALID   = 16;
  localparam int RDAT_PEND    = 17;
  localparam int MODE_PRE_BIT = 8;
  localparam int MODE_C45_BIT = 9;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic sampTa;
    logic sampDat;
    logic done;
    logic inPre;
    logic oe;
  } mdio_strb_t;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] halfPer,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             edgeNow;

  assign lim      = (halfPer == '0) ? DIV_W'(1) : halfPer;
  assign edgeNow  = run && (cnt == lim - DIV_W'(1));
  assign riseTick = edgeNow && !mdc;
  assign fallTick = edgeNow && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdc <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      mdc <= 1'b0;
      cnt <= '0;
    end else if (edgeNow) begin
      mdc <= ~mdc;
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       preOn,
  input  logic       isRead,
  input  logic       riseTick,
  input  logic       fallTick,
  output logic       run,
  output mdio_strb_t strb
);
  localparam int TOTAL = PRE_BITS + FRAME_BITS;
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] FIRST_FRM = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] OE_END    = CNT_W'(PRE_BITS + 14);
  localparam logic [CNT_W-1:0] TA_SECOND = CNT_W'(PRE_BITS + 15);
  localparam logic [CNT_W-1:0] DAT_FIRST = CNT_W'(PRE_BITS + 16);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t           state;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign run     = (state == ST_RUN);
  assign lastBit = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state  <= ST_RUN;
          bitCnt <= preOn ? '0 : FIRST_FRM;
        end
        ST_RUN: if (fallTick) begin
          if (lastBit) state <= ST_IDLE;
          else         bitCnt <= bitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && startReq;
    strb.shift   = run && fallTick && (bitCnt >= FIRST_FRM) && !lastBit;
    strb.done    = run && fallTick && lastBit;
    strb.sampTa  = run && riseTick && (bitCnt == TA_SECOND);
    strb.sampDat = run && riseTick && (bitCnt >= DAT_FIRST);
    strb.inPre   = run && (bitCnt < FIRST_FRM);
    strb.oe      = run && ((bitCnt < OE_END) || !isRead);
  end
endmodule

// File: rtl/mdio_dpath.sv
`timescale 1ns/1ps
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [1:0]       hostAddr,
  input  logic [31:0]      hostWrData,
  output logic [31:0]      hostRdData,
  input  mdio_strb_t       strb,
  input  logic             mdioIn,
  output logic             startReq,
  output logic             busy,
  output logic             isRead,
  output logic             preOn,
  output logic [DIV_W-1:0] halfPer,
  output logic             mdioOut,
  output logic             mdioOe
);
  logic [1:0]            cmdOp;
  logic [ADR_W-1:0]      cmdPhy, cmdReg;
  logic [DATA_W-1:0]     wrData, rdData, rdSr;
  logic                  rdValid, taOk, pendWr, pendRd;
  logic [DIV_W-1:0]      modeDiv;
  logic                  modePre, modeC45;
  logic [FRAME_BITS-1:0] frameSr, frameNew;
  logic [1:0]            newOp, wireOp, startFld;
  logic [ADR_W-1:0]      newPhy, newReg;
  logic                  newRead, regWrOk;
  logic                  unusedHostBits;

  assign busy     = pendWr | pendRd;
  assign regWrOk  = hostWrEn && !busy;
  assign startReq = regWrOk && (hostAddr == REG_CMD);
  assign preOn    = modePre | modeC45;
  assign halfPer  = modeDiv;

  // frame assembly from the command being written
  assign newOp    = hostWrData[1:0];
  assign newPhy   = hostWrData[CMD_PHY_LSB +: ADR_W];
  assign newReg   = hostWrData[CMD_REG_LSB +: ADR_W];
  assign newRead  = modeC45 ? newOp[1] : newOp[0];
  assign wireOp   = modeC45 ? newOp : (newOp[0] ? 2'b10 : 2'b01);
  assign startFld = modeC45 ? 2'b00 : 2'b01;
  assign frameNew = {startFld, wireOp, newPhy, newReg, 2'b10, wrData};
  assign unusedHostBits = ^{hostWrData[31:21], hostWrData[7:2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOp   <= '0;
      cmdPhy  <= '0;
      cmdReg  <= '0;
      wrData  <= '0;
      rdData  <= '0;
      rdSr    <= '0;
      rdValid <= 1'b0;
      taOk    <= 1'b0;
      pendWr  <= 1'b0;
      pendRd  <= 1'b0;
      modeDiv <= '0;
      modePre <= 1'b0;
      modeC45 <= 1'b0;
      frameSr <= '0;
      isRead  <= 1'b0;
    end else begin
      if (strb.load) begin
        cmdOp   <= newOp;
        cmdPhy  <= newPhy;
        cmdReg  <= newReg;
        frameSr <= frameNew;
        isRead  <= newRead;
        taOk    <= 1'b0;
        if (newRead) begin
          pendRd  <= 1'b1;
          rdValid <= 1'b0;
        end else begin
          pendWr  <= 1'b1;
        end
      end
      if (regWrOk && hostAddr == REG_WDAT) wrData <= hostWrData[DATA_W-1:0];
      if (regWrOk && hostAddr == REG_MODE) begin
        modeDiv <= hostWrData[DIV_W-1:0];
        modePre <= hostWrData[MODE_PRE_BIT];
        modeC45 <= hostWrData[MODE_C45_BIT];
      end
      if (strb.shift)   frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
      if (strb.sampTa)  taOk    <= !mdioIn;
      if (strb.sampDat) rdSr    <= {rdSr[DATA_W-2:0], mdioIn};
      if (strb.done) begin
        pendWr <= 1'b0;
        pendRd <= 1'b0;
        if (isRead) begin
          rdData  <= rdSr;
          rdValid <= taOk;
        end
      end
    end
  end

  assign mdioOe  = strb.oe;
  assign mdioOut = (strb.inPre || !strb.oe) ? 1'b1 : frameSr[FRAME_BITS-1];

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      REG_CMD: begin
        hostRdData[1:0]                      = cmdOp;
        hostRdData[CMD_PHY_LSB +: ADR_W]     = cmdPhy;
        hostRdData[CMD_REG_LSB +: ADR_W]     = cmdReg;
      end
      REG_WDAT: begin
        hostRdData[DATA_W-1:0] = wrData;
        hostRdData[WDAT_PEND]  = pendWr;
      end
      REG_RDAT: begin
        hostRdData[DATA_W-1:0] = rdData;
        hostRdData[RDAT_VALID] = rdValid;
        hostRdData[RDAT_PEND]  = pendRd;
      end
      default: begin
        hostRdData[DIV_W-1:0]    = modeDiv;
        hostRdData[MODE_PRE_BIT] = modePre;
        hostRdData[MODE_C45_BIT] = modeC45;
      end
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_strb_t       strb;
  logic             startReq, busy, isRead, preOn, run, riseTick, fallTick;
  logic [DIV_W-1:0] halfPer;

  mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rstN(rstN), .run(run), .halfPer(halfPer),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .preOn(preOn),
    .isRead(isRead), .riseTick(riseTick), .fallTick(fallTick),
    .run(run), .strb(strb)
  );

  mdio_dpath #(.DIV_W(DIV_W)) dpath_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .strb(strb),
    .mdioIn(mdioIn), .startReq(startReq), .busy(busy), .isRead(isRead),
    .preOn(preOn), .halfPer(halfPer), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       hostWrEn,
  input logic [1:0] hostAddr,
  input logic       load,
  input logic       done,
  input logic       inPre
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    load |=> busy);  // R1
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));  // R2
  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    inPre |-> (mdioOut && mdioOe));  // R3
  AST_CHANGE_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (mdioOut != $past(mdioOut) || mdioOe != $past(mdioOe))) |-> !mdc);  // R8
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn && hostAddr == 2'd0) |-> !load);  // R9
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .load(strb.load), .done(strb.done), .inPre(strb.inPre)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  typedef struct {
    logic [63:0] val;
    logic [63:0] oe;
    logic [63:0] care;
    int          len;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  time         riseT[$];
  int          nChk = 0, nFail = 0, r8Bad = 0, recCnt = 0;
  logic [63:0] recVal = '0, recOe = '0;
  logic        lastRiseVal = 1'b1;
  logic        curPre = 1'b0, curRead = 1'b0, respTa = 1'b0;
  logic [15:0] respData = '0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: sample bus just after every rising management clock edge
  always @(posedge mdc) begin
    #1;
    if (recCnt < 64) begin
      recVal[63-recCnt] = mdioOut;
      recOe[63-recCnt]  = mdioOe;
    end
    lastRiseVal = mdioOut;
    riseT.push_back($time);
    recCnt++;
  end

  // R8: driven value must hold while the management clock is high
  always @(negedge clk) if (mdc && mdioOut !== lastRiseVal) r8Bad++;

  // PHY model: changes the line after falling edges only
  always @(negedge mdc) begin
    int pos;
    pos = recCnt - (curPre ? 32 : 0);
    if (curRead && pos == 15) mdioIn = respTa;
    else if (curRead && pos >= 16 && pos <= 31) mdioIn = respData[31-pos];
    else mdioIn = 1'b1;
  end

  // scoreboard: compare each finished frame with the queued expectation
  initial begin
    forever begin
      exp_t        e;
      logic [63:0] lenMask;
      wait (expQ.size() > 0);
      wait (recCnt >= expQ[0].len);
      e = expQ.pop_front();
      lenMask = (e.len == 64) ? '1 : {32'hFFFF_FFFF, 32'h0};
      check(((recOe ^ e.oe) & lenMask) == '0, e.tag, "drive enable per bit", recOe & lenMask, e.oe);
      check(((recVal ^ e.val) & e.care) == '0, e.tag, "driven bits", recVal & e.care, e.val & e.care);
      recCnt = 0;
    end
  end

  function automatic exp_t mkFrame(input bit c45, input bit pre, input logic [1:0] op,
                                   input logic [4:0] phy, input logic [4:0] ra,
                                   input logic [15:0] wd, input string tag);
    exp_t        e;
    logic        isRd;
    logic [1:0]  wop, st;
    logic [31:0] f, oeF;
    isRd = c45 ? op[1] : op[0];
    wop  = c45 ? op : (op[0] ? 2'b10 : 2'b01);
    st   = c45 ? 2'b00 : 2'b01;
    f    = {st, wop, phy, ra, 2'b10, wd};
    oeF  = isRd ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
    if (pre || c45) begin
      e.val = {32'hFFFF_FFFF, f}; e.oe = {32'hFFFF_FFFF, oeF};
      e.care = e.oe; e.len = 64;
    end else begin
      e.val = {f, 32'h0}; e.oe = {oeF, 32'h0}; e.care = e.oe; e.len = 32;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] w, r;
    for (int i = 0; i < 20000; i++) begin
      hostRead(2'd1, w);
      hostRead(2'd2, r);
      if (!w[16] && !r[17]) break;
    end
  endtask

  task automatic setMode(input logic [7:0] div, input bit pre, input bit c45);
    hostWrite(2'd3, {22'h0, c45, pre, div});
  endtask

  task automatic runCmd(input bit c45, input bit pre, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input string tag);
    expQ.push_back(mkFrame(c45, pre, op, phy, ra, wd, tag));
    curPre  = pre || c45;
    curRead = c45 ? op[1] : op[0];
    mdioIn  = 1'b1;
    riseT.delete();
    hostWrite(2'd0, {11'h0, ra, 3'h0, phy, 6'h0, op});
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      hostRead(a[1:0], v);
      check(v == 32'h0, "R10", "register after reset", v, 0);
    end
    check(!mdc && !mdioOe, "R10", "bus idle after reset", {mdc, mdioOe}, 0);

    // R4/R6: direct write frame without preamble, R2 phase length 2, R9 ignore
    setMode(8'd2, 1'b0, 1'b0);
    hostWrite(2'd1, 32'h0000_A5C3);
    runCmd(1'b0, 1'b0, 2'd0, 5'h11, 5'h0A, 16'hA5C3, "R4 R6 direct write");
    hostRead(2'd1, v);
    check(v[16] == 1'b1, "R1", "write busy flag set", v[16], 1);
    hostRead(2'd2, v);
    check(v[17] == 1'b0, "R1", "read busy flag clear on write", v[17], 0);
    hostWrite(2'd0, 32'h001F_1F01);
    hostWrite(2'd1, 32'h0000_1234);
    hostWrite(2'd3, 32'h0000_0305);
    waitIdle();
    check(riseT.size() >= 2 && (riseT[1] - riseT[0]) == 16, "R2", "clock period div=2",
          riseT.size() >= 2 ? 64'(riseT[1] - riseT[0]) : 0, 16);
    hostRead(2'd0, v);
    check(v == 32'h000A_1100, "R9", "command kept while busy", v, 32'h000A_1100);
    hostRead(2'd1, v);
    check(v == 32'h0000_A5C3, "R9", "write data kept, busy cleared", v, 32'h0000_A5C3);
    hostRead(2'd3, v);
    check(v == 32'h0000_0002, "R9", "mode kept while busy", v, 32'h2);

    // R7/R3: direct read with preamble, good turnaround, phase length 3
    setMode(8'd3, 1'b1, 1'b0);
    respData = 16'h5AF0; respTa = 1'b0;
    runCmd(1'b0, 1'b1, 2'd1, 5'h03, 5'h1F, 16'hA5C3, "R3 R4 R7 direct read");
    hostRead(2'd2, v);
    check(v[17] == 1'b1, "R1", "read busy flag set", v[17], 1);
    waitIdle();
    check(riseT.size() >= 2 && (riseT[1] - riseT[0]) == 24, "R2", "clock period div=3",
          riseT.size() >= 2 ? 64'(riseT[1] - riseT[0]) : 0, 24);
    hostRead(2'd2, v);
    check(v == 32'h0001_5AF0, "R7", "read data and valid", v, 32'h0001_5AF0);

    // R7: turnaround not pulled low gives no valid
    respData = 16'h0F0F; respTa = 1'b1;
    runCmd(1'b0, 1'b1, 2'd1, 5'h04, 5'h02, 16'hA5C3, "R7 failed read");
    waitIdle();
    hostRead(2'd2, v);
    check(v[16] == 1'b0 && v[17] == 1'b0, "R7", "valid clear after no response", v, 32'h0000_0F0F);

    // R5/R3: extended address frame, preamble forced, divider 0 acts as 1
    setMode(8'd0, 1'b0, 1'b1);
    hostWrite(2'd1, 32'h0000_0123);
    runCmd(1'b1, 1'b0, 2'd0, 5'h03, 5'h01, 16'h0123, "R3 R5 extended address");
    waitIdle();
    check(riseT.size() >= 2 && (riseT[1] - riseT[0]) == 8, "R2", "clock period div=0",
          riseT.size() >= 2 ? 64'(riseT[1] - riseT[0]) : 0, 8);

    // R5/R6: extended write
    setMode(8'd1, 1'b1, 1'b1);
    hostWrite(2'd1, 32'h0000_BEEF);
    runCmd(1'b1, 1'b1, 2'd1, 5'h1C, 5'h1E, 16'hBEEF, "R5 R6 extended write");
    waitIdle();

    // R5/R7: extended read with increment and plain read
    respData = 16'hC0DE; respTa = 1'b0;
    runCmd(1'b1, 1'b1, 2'd2, 5'h02, 5'h03, 16'hBEEF, "R5 R7 extended read-inc");
    waitIdle();
    hostRead(2'd2, v);
    check(v == 32'h0001_C0DE, "R7", "extended read-inc data", v, 32'h0001_C0DE);
    respData = 16'h8001;
    runCmd(1'b1, 1'b1, 2'd3, 5'h07, 5'h04, 16'hBEEF, "R5 R7 extended read");
    waitIdle();
    hostRead(2'd2, v);
    check(v == 32'h0001_8001, "R7", "extended read data", v, 32'h0001_8001);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R1", "all frames seen", expQ.size(), 0);
    check(r8Bad == 0, "R8", "line stable while clock high", r8Bad, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule